// File: doc/BRIEF.md
# Programmable Address Aperture Remapper

This block sits on the address path of one or more bus masters and rewrites each 32-bit request address before it enters the interconnect. The 4 GB space is cut into sixteen 256 MB apertures, chosen by the top four address bits. Each aperture carries a 4-bit target slave number and a 4-bit target aperture number. The target aperture number becomes the new top nibble of the address the slave sees. Slave number 0 marks an aperture with no target. A request that hits such an aperture raises a decode-error flag, so the fabric can return a decode-error response and no slave is selected.

Each master has its own group of four 32-bit registers that software programs. Writes land in a shadow copy and do not touch the working map. A single update register holds one bit per master. Writing it copies the shadow map of every master whose bit is set into that master's working map in one cycle, so several maps can switch at the same instant. Translation is combinational from the working map. A register read is also combinational and returns the shadow contents.

Top module: `aperture_remap`

## Requirements
- R1: For master m, the aperture index is mstAddr[31:28] and slvSel is the 4-bit slave entry of that aperture in m's working map. Slave entries for apertures 0..7 sit in the group register at offset 0x0 and those for apertures 8..15 at offset 0x4. Entry i of a register is at bits [4i+3:4i] (i counted within the register).
- R2: slvAddr for master m is {offset entry of the aperture, mstAddr[27:0]}. Offset entries use the same nibble packing, at offset 0x8 for apertures 0..7 and offset 0xC for apertures 8..15.
- R3: When the selected slave entry is 0, decErr for that master is 1 and slvSel is 0. Otherwise decErr is 0.
- R4: A write to a group register does not change any translation until an update write commits it.
- R5: A write to the update register at byte address 0x100 copies the shadow map of master m into its working map when data bit m is 1. The new map is seen from the next clock cycle. Masters whose bit is 0 keep their working map.
- R6: The register group of master m is at byte address 16*m + {0x0,0x4,0x8,0xC}. A write to it changes only master m's map.
- R7: regRdData returns, in the same cycle, the shadow value of the addressed group register. A read of the update register or of any unmapped address returns 0.
- R8: After reset all shadow and working entries are 0. Every aperture of every master then reports decErr = 1, and all reads return 0.
- R9: Writes to addresses outside the groups of existing masters and outside the update register, including groups at or above NUM_MASTERS and addresses not aligned to 4 bytes, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W (12) | Register byte address, used for both writes and reads |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data of the register at regAddr |
| mstAddr | input | 32*NUM_MASTERS | Request address of each master, master m at bits [32m+31:32m] |
| slvSel | output | 4*NUM_MASTERS | Selected slave number for each master |
| slvAddr | output | 32*NUM_MASTERS | Rewritten address for each master |
| decErr | output | NUM_MASTERS | Decode error for each master (aperture has no target) |

## Verification
A corrupted working map shows up at once as a wrong slvSel, a wrong slvAddr top nibble or a false decErr, on the same cycle a request hits the damaged aperture. The bench therefore probes many apertures per master after every register operation. A shadow entry that leaks early into the working map shows as a translation change before any update write. A missed or misrouted commit shows one cycle after the update write as a master still on its old map, or a master that changed when its bit was 0. Shadow corruption shows through combinational readback.

// File: rtl/aperture_remap_pkg.sv
package aperture_remap_pkg;

  localparam int APER_BITS = 4;
  localparam int LOW_BITS  = 28;
  localparam int WORDS     = 4;

  // Strobes from register decode to the map storage
  typedef struct packed {
    logic        grpWe;   // write to a valid group register
    logic        updWe;   // write to the update register
    logic        grpHit;  // address selects a valid group register
    logic [3:0]  grp;     // group (master) index
    logic [1:0]  sel;     // word within group
    logic [31:0] data;    // write data
  } strobe_t;

endpackage

// File: rtl/aperture_remap_ctrl.sv
module aperture_remap_ctrl
  import aperture_remap_pkg::*;
#(
  parameter int NUM_MASTERS = 2,
  parameter int ADDR_W      = 12,
  parameter int UPD_ADDR    = 'h100
) (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output strobe_t           strobe
);

  logic inGroupSpace;
  logic grpInRange;
  logic grpHit;
  logic updHit;

  assign inGroupSpace = (regAddr[ADDR_W-1:8] == '0) && (regAddr[1:0] == 2'b00);
  assign grpInRange   = {1'b0, regAddr[7:4]} < 5'(NUM_MASTERS);
  assign grpHit       = inGroupSpace && grpInRange;
  assign updHit       = (regAddr == ADDR_W'(UPD_ADDR));

  always_comb begin
    strobe.grpWe  = regWrEn && grpHit;
    strobe.updWe  = regWrEn && updHit;
    strobe.grpHit = grpHit;
    strobe.grp    = regAddr[7:4];
    strobe.sel    = regAddr[3:2];
    strobe.data   = regWrData;
  end

endmodule

// File: rtl/aperture_remap_dp.sv
module aperture_remap_dp
  import aperture_remap_pkg::*;
#(
  parameter int NUM_MASTERS = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  strobe,
  input  logic [32*NUM_MASTERS-1:0] mstAddr,
  output logic [31:0]              regRdData,
  output logic [4*NUM_MASTERS-1:0] slvSel,
  output logic [32*NUM_MASTERS-1:0] slvAddr,
  output logic [NUM_MASTERS-1:0]   decErr
);

  logic [31:0] shadowQ [NUM_MASTERS][WORDS];
  logic [31:0] activeQ [NUM_MASTERS][WORDS];
  logic [31:0] rdPart  [NUM_MASTERS];

  for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_mst
    localparam logic [3:0] MID = 4'(m);

    // shadow and working map storage
    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int w = 0; w < WORDS; w++) begin
          shadowQ[m][w] <= '0;
          activeQ[m][w] <= '0;
        end
      end else begin
        if (strobe.grpWe && strobe.grp == MID)
          shadowQ[m][strobe.sel] <= strobe.data;
        if (strobe.updWe && strobe.data[m])
          for (int w = 0; w < WORDS; w++)
            activeQ[m][w] <= shadowQ[m][w];
      end
    end

    // translation
    logic [APER_BITS-1:0] aper;
    logic [31:0]          selWord;
    logic [31:0]          offWord;
    logic [3:0]           selNib;
    logic [3:0]           offNib;

    assign aper    = mstAddr[32*m+31 -: APER_BITS];
    assign selWord = activeQ[m][{1'b0, aper[3]}];
    assign offWord = activeQ[m][{1'b1, aper[3]}];
    assign selNib  = 4'(selWord >> {aper[2:0], 2'b00});
    assign offNib  = 4'(offWord >> {aper[2:0], 2'b00});

    assign slvSel[4*m+3 -: 4]   = selNib;
    assign decErr[m]            = (selNib == 4'd0);
    assign slvAddr[32*m+31 -: 32] = {offNib, mstAddr[32*m+LOW_BITS-1 -: LOW_BITS]};

    assign rdPart[m] = (strobe.grpHit && strobe.grp == MID) ? shadowQ[m][strobe.sel] : '0;
  end

  always_comb begin
    regRdData = '0;
    for (int m = 0; m < NUM_MASTERS; m++)
      regRdData = regRdData | rdPart[m];
  end

endmodule

// File: rtl/aperture_remap.sv
module aperture_remap
  import aperture_remap_pkg::*;
#(
  parameter int NUM_MASTERS = 2,
  parameter int ADDR_W      = 12,
  parameter int UPD_ADDR    = 'h100
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      regWrEn,
  input  logic [ADDR_W-1:0]         regAddr,
  input  logic [31:0]               regWrData,
  output logic [31:0]               regRdData,
  input  logic [32*NUM_MASTERS-1:0] mstAddr,
  output logic [4*NUM_MASTERS-1:0]  slvSel,
  output logic [32*NUM_MASTERS-1:0] slvAddr,
  output logic [NUM_MASTERS-1:0]    decErr
);

  strobe_t strobe;

  aperture_remap_ctrl #(
    .NUM_MASTERS(NUM_MASTERS),
    .ADDR_W     (ADDR_W),
    .UPD_ADDR   (UPD_ADDR)
  ) u_ctrl (
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .strobe   (strobe)
  );

  aperture_remap_dp #(
    .NUM_MASTERS(NUM_MASTERS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .mstAddr  (mstAddr),
    .regRdData(regRdData),
    .slvSel   (slvSel),
    .slvAddr  (slvAddr),
    .decErr   (decErr)
  );

endmodule

// File: rtl/aperture_remap_chk.sv
module aperture_remap_chk #(
  parameter int NUM_MASTERS = 2,
  parameter int ADDR_W      = 12,
  parameter int UPD_ADDR    = 'h100
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      regWrEn,
  input logic [ADDR_W-1:0]         regAddr,
  input logic [31:0]               regWrData,
  input logic [31:0]               regRdData,
  input logic [32*NUM_MASTERS-1:0] mstAddr,
  input logic [4*NUM_MASTERS-1:0]  slvSel,
  input logic [32*NUM_MASTERS-1:0] slvAddr,
  input logic [NUM_MASTERS-1:0]    decErr
);

  logic wrWord0;
  assign wrWord0 = regWrEn && (regAddr == '0);

  // R7: shadow word written at address 0 reads back on the next cycle
  p_readback_r7: assert property (@(posedge clk) disable iff (!rstN)
    wrWord0 |=> ((regAddr != '0) || (regRdData == $past(regWrData))));

  // R8: leaving reset, every master reports no target
  p_reset_state_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (decErr == '1));

  for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_chk
    logic commitM;
    assign commitM = regWrEn && (regAddr == ADDR_W'(UPD_ADDR)) && regWrData[m];

    // R2: low 28 address bits pass unchanged
    p_low_bits_r2: assert property (@(posedge clk) disable iff (!rstN)
      slvAddr[32*m+27 -: 28] == mstAddr[32*m+27 -: 28]);

    // R4: without a commit for this master the translation of a steady address holds
    p_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
      ($stable(mstAddr[32*m+31 -: 32]) && !$past(commitM))
        |-> ($stable(slvSel[4*m+3 -: 4]) && $stable(slvAddr[32*m+31 -: 4])
             && $stable(decErr[m])));

    // R3: an error flag never comes with a selected slave
    p_no_slave_on_err_r3: assert property (@(posedge clk) disable iff (!rstN)
      decErr[m] |-> (slvSel[4*m+3 -: 4] == 4'd0));
  end

endmodule

bind aperture_remap aperture_remap_chk #(
  .NUM_MASTERS(NUM_MASTERS),
  .ADDR_W     (ADDR_W),
  .UPD_ADDR   (UPD_ADDR)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regWrEn  (regWrEn),
  .regAddr  (regAddr),
  .regWrData(regWrData),
  .regRdData(regRdData),
  .mstAddr  (mstAddr),
  .slvSel   (slvSel),
  .slvAddr  (slvAddr),
  .decErr   (decErr)
);

// File: tb/aperture_remap_bench.sv
module aperture_remap_bench;

  localparam int NM = 2;
  localparam int AW = 12;

  logic            clk = 1'b0;
  logic            rstN;
  logic            regWrEn;
  logic [AW-1:0]   regAddr;
  logic [31:0]     regWrData;
  logic [31:0]     regRdData;
  logic [32*NM-1:0] mstAddr;
  logic [4*NM-1:0] slvSel;
  logic [32*NM-1:0] slvAddr;
  logic [NM-1:0]   decErr;

  int testCnt = 0;
  int failCnt = 0;
  bit done = 0;

  logic [31:0] shad [NM][4];
  logic [31:0] act  [NM][4];

  always #10 clk = ~clk;

  aperture_remap #(.NUM_MASTERS(NM), .ADDR_W(AW), .UPD_ADDR('h100)) u_aperture_remap (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .mstAddr(mstAddr),
    .slvSel(slvSel), .slvAddr(slvAddr), .decErr(decErr));

  function automatic logic [3:0] eSel(int m, logic [31:0] a);
    logic [31:0] w;
    w = act[m][a[31] ? 1 : 0];
    return w[4*a[30:28] +: 4];
  endfunction

  function automatic logic [3:0] eOff(int m, logic [31:0] a);
    logic [31:0] w;
    w = act[m][a[31] ? 3 : 2];
    return w[4*a[30:28] +: 4];
  endfunction

  function automatic logic [31:0] eRead(logic [AW-1:0] a);
    if (a[AW-1:8] == '0 && a[1:0] == 2'b00 && int'(a[7:4]) < NM)
      return shad[int'(a[7:4])][int'(a[3:2])];
    return 32'h0;
  endfunction

  // write a register and mirror it in the model (R5, R6, R9)
  task automatic wrReg(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    if (a == 'h100) begin
      for (int m = 0; m < NM; m++)
        if (d[m]) for (int w = 0; w < 4; w++) act[m][w] = shad[m][w];
    end else if (a[AW-1:8] == '0 && a[1:0] == 2'b00 && int'(a[7:4]) < NM) begin
      shad[int'(a[7:4])][int'(a[3:2])] = d;
    end
  endtask

  task automatic chkXlate(int m, logic [31:0] a, string tag);
    logic [3:0]  es;
    logic [31:0] ea;
    mstAddr[32*m +: 32] = a;
    #2;
    es = eSel(m, a);
    ea = {eOff(m, a), a[27:0]};
    testCnt++;
    if (slvSel[4*m +: 4] !== es || decErr[m] !== (es == 4'd0) || slvAddr[32*m +: 32] !== ea) begin
      failCnt++;
      $display("FAIL %s m%0d addr=%h: sel=%h err=%b out=%h, expected sel=%h err=%b out=%h",
               tag, m, a, slvSel[4*m +: 4], decErr[m], slvAddr[32*m +: 32],
               es, (es == 4'd0), ea);
    end
  endtask

  task automatic chkRead(logic [AW-1:0] a, string tag);
    @(negedge clk);
    regAddr = a;
    #2;
    testCnt++;
    if (regRdData !== eRead(a)) begin
      failCnt++;
      $display("FAIL %s read %h: got %h expected %h", tag, a, regRdData, eRead(a));
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    testCnt++; failCnt++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'h1f2e3d));
    for (int m = 0; m < NM; m++)
      for (int w = 0; w < 4; w++) begin shad[m][w] = '0; act[m][w] = '0; end
    rstN = 1'b0; regWrEn = 1'b0; regAddr = '0; regWrData = '0; mstAddr = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R8: reset state
    @(negedge clk);
    chkXlate(0, 32'h8000_1234, "R8");
    chkXlate(1, 32'hF000_0000, "R8");
    chkRead('h00C, "R8");
    chkRead('h014, "R8");

    // R4: program master 0 shadow, no commit yet
    wrReg('h000, 32'h2000_0133);
    wrReg('h004, 32'h6330_1111);
    wrReg('h008, 32'h0000_0010);
    wrReg('h00C, 32'h0ED0_3210);
    chkXlate(0, 32'h0123_4567, "R4");
    chkXlate(0, 32'h9ABC_DEF0, "R4");
    chkRead('h004, "R7");
    chkRead('h100, "R7");

    // R5: commit master 0 only
    wrReg('h100, 32'h0000_0001);
    chkXlate(0, 32'h0FFF_FFFF, "R1");
    chkXlate(0, 32'h1000_0000, "R2");
    chkXlate(0, 32'h2ABC_0000, "R1");
    chkXlate(0, 32'h3000_0004, "R3");
    chkXlate(0, 32'h9000_0100, "R2");
    chkXlate(0, 32'hE123_0000, "R2");
    chkXlate(0, 32'hFFFF_FFFF, "R1");
    chkXlate(1, 32'h9000_0100, "R5");

    // R6: master 1 group leaves master 0 alone
    wrReg('h010, 32'h7777_7777);
    wrReg('h100, 32'h0000_0002);
    chkXlate(1, 32'h5000_0000, "R6");
    chkXlate(0, 32'h5000_0000, "R6");

    // R9: unmapped, misaligned and out-of-range writes change nothing
    wrReg('h040, 32'hFFFF_FFFF);
    wrReg('h001, 32'hFFFF_FFFF);
    wrReg('h200, 32'hFFFF_FFFF);
    wrReg('h100, 32'h0000_0003);
    chkRead('h000, "R9");
    chkRead('h040, "R9");
    chkXlate(0, 32'h0000_0000, "R9");
    chkXlate(1, 32'h4000_0000, "R9");

    // random mix
    for (int it = 0; it < 500; it++) begin
      int op;
      op = int'($urandom % 8);
      if (op < 4) begin
        logic [AW-1:0] a;
        a = {4'h0, 4'($urandom % 3), 2'($urandom), 2'b00};
        if ($urandom % 10 == 0) a = AW'($urandom);
        wrReg(a, $urandom);
      end else if (op < 6) begin
        wrReg('h100, $urandom % 8);
      end else begin
        logic [AW-1:0] a;
        a = {4'h0, 4'($urandom % 3), 2'($urandom), 2'b00};
        chkRead(a, "R7");
      end
      for (int k = 0; k < 3; k++) begin
        chkXlate(0, $urandom, "R1");
        chkXlate(1, $urandom, "R2");
      end
    end

    summary();
  end

endmodule